// File: doc/BRIEF.md
# UART Transmit/Receive Buffering and Status Flags

This block sits between a processor-facing register port and the bit shifters of a UART. Transmit bytes written by the processor wait in a transmit buffer until the serializer takes them over a valid/ready handshake. Bytes assembled by the deserializer wait in a receive buffer until the processor reads them. A single mode input picks how deep both buffers are. With the input low, each direction holds exactly one byte, like a plain holding register. With the input high, each direction is a first-in first-out queue of `DEPTH` bytes.

The block drives registered status flags for software to poll: transmit full, receive full, receive empty, a transmitter-busy indication and a carrier-detect mirror. The busy flag counts a byte as in flight from the moment it is queued, even when the UART enable is low. It stays set until the serializer reports that the final stop bit of the last byte has gone out. The carrier-detect mirror exists only in builds with modem signals enabled. Otherwise it reads as zero.

Top module: `uart_bufstat`

## Requirements
- R1: After a synchronous reset, `rx_empty` is 1 and `rx_full`, `tx_full`, `busy` and `dcd` are 0.
- R2: With `fifo_en`=0 each direction stores one byte. With `fifo_en`=1 each direction stores `DEPTH` bytes (16 by default). Bytes leave in the order they entered.
- R3: `tx_full` is 1 exactly when the transmit buffer holds its capacity for the current mode (one byte or `DEPTH` bytes).
- R4: `rx_full` is 1 exactly when the receive buffer holds its capacity for the current mode.
- R5: `rx_empty` is 1 exactly when the receive buffer holds no byte.
- R6: A processor write while the transmit buffer is full is dropped. A received byte that arrives while the receive buffer is full is discarded. Fullness is judged on the occupancy before any pop in the same cycle.
- R7: In a cycle where `fifo_en` differs from its value in the previous cycle, both buffers are emptied. Pushes and pops in that cycle are ignored, and `tx_valid` is 0.
- R8: `tx_valid` is 1 when `uart_en` is 1, the transmit buffer is not empty and no mode change is under way. `tx_data` is the oldest queued byte. The byte is removed on a cycle with `tx_valid` and `tx_ready` both 1. A processor read with `cpu_rd_en` removes the oldest received byte, which is shown on `cpu_rd_data` while the buffer is not empty.
- R9: `busy` is 1 whenever the transmit buffer holds a byte, whether `uart_en` is 1 or 0.
- R10: After a byte is handed to the serializer, `busy` stays 1 until the edge that samples `tx_done`=1, unless another byte is handed over on that same edge.
- R11: With `MODEM_EN`=1, `dcd` equals `carrier_in` delayed by one clock. With `MODEM_EN`=0, `dcd` is always 0.
- R12: All flags are registered. After the edge that takes a push, pop or flush, each flag shows the new occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Buffer mode: 0 one-byte holding, 1 queue of DEPTH |
| uart_en | input | 1 | UART enable; gates hand-off to the serializer |
| cpu_wr_en | input | 1 | Processor write strobe for transmit data |
| cpu_wr_data | input | DATA_W | Processor transmit byte |
| cpu_rd_en | input | 1 | Processor read strobe for receive data |
| cpu_rd_data | output | DATA_W | Oldest received byte |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | DATA_W | Deserialized byte |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | DATA_W | Offered byte |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_done | input | 1 | Serializer finished the final stop bit |
| carrier_in | input | 1 | External carrier-detect input |
| tx_full | output | 1 | Transmit buffer full |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |
| busy | output | 1 | Transmitter busy |
| dcd | output | 1 | Carrier-detect mirror |

## Verification
Both buffers are first loaded past capacity in each mode with the shifter idle. This separates the one-byte limit from the DEPTH limit and shows that overflowing bytes are dropped. Writes with `uart_en` low show that busy follows queued data and not transmission. A draining phase with shifter lengths that vary and a `tx_ready` that comes and goes tells a busy that waits for `tx_done` apart from one that drops when the buffer empties. Long mixed traffic with occasional mode flips, simultaneous push and pop at full, and toggling carrier checks flush timing, ordering and the registered flag update on every clock against a queue-based model.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  typedef enum logic {
    MODE_HOLD = 1'b0,
    MODE_QUEUE = 1'b1
  } buf_mode_e;
endpackage

// File: rtl/ubs_fifo.sv
module ubs_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [CNT_W-1:0]  cap,
  input  logic              push_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic              nonempty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  // capacity judged on occupancy before any same-cycle pop
  assign push_ok  = push_req && !flush && (cnt_q < cap);
  assign pop_ok   = pop_req && !flush && (cnt_q != '0);
  assign nonempty = (cnt_q != '0);
  assign rdata    = mem[rd_ptr];

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ubs_txtrack.sv
module ubs_txtrack (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic done,
  input  logic queued_nxt,
  output logic busy
);
  logic active_q, active_nxt;

  always_comb begin
    if (launch)    active_nxt = 1'b1;
    else if (done) active_nxt = 1'b0;
    else           active_nxt = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      busy     <= 1'b0;
    end else begin
      active_q <= active_nxt;
      busy     <= queued_nxt || active_nxt;
    end
  end
endmodule

// File: rtl/uart_bufstat.sv
module uart_bufstat
  import ubs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter bit MODEM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              uart_en,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              tx_done,
  input  logic              carrier_in,
  output logic              tx_full,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              busy,
  output logic              dcd
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  buf_mode_e        mode_q, mode_now;
  logic             mode_chg;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] tx_cnt_nxt, rx_cnt_nxt;
  logic             tx_nonempty, rx_nonempty;
  logic             tx_pop;

  assign mode_now = buf_mode_e'(fifo_en);
  assign mode_chg = (mode_now != mode_q);
  assign cap      = (mode_now == MODE_QUEUE) ? CNT_W'(DEPTH) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_now;
    else     mode_q <= mode_now;
  end

  assign tx_valid = uart_en && tx_nonempty && !mode_chg;
  assign tx_pop   = tx_valid && tx_ready;

  ubs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_buf_i (
    .clk(clk), .rst(rst), .flush(mode_chg), .cap(cap),
    .push_req(cpu_wr_en), .wdata(cpu_wr_data),
    .pop_req(tx_pop), .rdata(tx_data),
    .cnt_nxt(tx_cnt_nxt), .nonempty(tx_nonempty)
  );

  ubs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_buf_i (
    .clk(clk), .rst(rst), .flush(mode_chg), .cap(cap),
    .push_req(rx_valid), .wdata(rx_data),
    .pop_req(cpu_rd_en && rx_nonempty), .rdata(cpu_rd_data),
    .cnt_nxt(rx_cnt_nxt), .nonempty(rx_nonempty)
  );

  ubs_txtrack busy_i (
    .clk(clk), .rst(rst), .launch(tx_pop), .done(tx_done),
    .queued_nxt(tx_cnt_nxt != '0), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full  <= 1'b0;
      rx_full  <= 1'b0;
      rx_empty <= 1'b1;
    end else begin
      tx_full  <= (tx_cnt_nxt >= cap);
      rx_full  <= (rx_cnt_nxt >= cap);
      rx_empty <= (rx_cnt_nxt == '0);
    end
  end

  generate
    if (MODEM_EN) begin : g_modem
      always_ff @(posedge clk) begin
        if (rst) dcd <= 1'b0;
        else     dcd <= carrier_in;
      end
    end else begin : g_nomodem
      assign dcd = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ubs_chk.sv
module ubs_chk (
  input logic clk,
  input logic rst,
  input logic fifo_en,
  input logic uart_en,
  input logic cpu_wr_en,
  input logic rx_valid,
  input logic cpu_rd_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_full,
  input logic rx_full,
  input logic rx_empty,
  input logic busy
);
  // R5
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !rx_full);

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    tx_full && cpu_wr_en && !(tx_valid && tx_ready) && $stable(fifo_en) |=> tx_full);

  // R7
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fifo_en) |=> rx_empty && !tx_full);

  // R8
  gate_uart_chk: assert property (@(posedge clk) disable iff (rst)
    !uart_en |-> !tx_valid);

  // R9
  busy_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_en && !tx_full && $stable(fifo_en) |=> busy);

  // R9
  offer_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  // R12
  rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !cpu_rd_en && $stable(fifo_en) |=> !rx_empty);
endmodule

bind uart_bufstat ubs_chk chk_i (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .uart_en(uart_en),
  .cpu_wr_en(cpu_wr_en), .rx_valid(rx_valid), .cpu_rd_en(cpu_rd_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_full(tx_full),
  .rx_full(rx_full), .rx_empty(rx_empty), .busy(busy)
);

// File: tb/uart_bufstat_tb_top.sv
`timescale 1ns/1ps
module uart_bufstat_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, uart_en = 1'b0;
  logic cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, rx_valid = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0, rx_data = '0;
  logic carrier_in = 1'b0;
  logic ready_en = 1'b0;
  int   sh_len = 4;
  int   sh_cnt = 0;
  logic tx_ready, tx_done;
  logic [DW-1:0] cpu_rd_data, tx_data;
  logic tx_valid, tx_full, rx_full, rx_empty, busy, dcd;
  logic [DW-1:0] n_rd, n_txd;
  logic n_txv, n_txf, n_rxf, n_rxe, n_busy, n_dcd;

  always #2 clk = ~clk;

  assign tx_done  = (sh_cnt == 1);
  assign tx_ready = ready_en && (sh_cnt <= 1);

  uart_bufstat #(.DATA_W(DW), .DEPTH(DEPTH), .MODEM_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .uart_en(uart_en),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(cpu_rd_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .carrier_in(carrier_in), .tx_full(tx_full), .rx_full(rx_full),
    .rx_empty(rx_empty), .busy(busy), .dcd(dcd));

  uart_bufstat #(.DATA_W(DW), .DEPTH(DEPTH), .MODEM_EN(1'b0)) dut_nomodem_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .uart_en(uart_en),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(n_rd), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(n_txv), .tx_data(n_txd), .tx_ready(tx_ready), .tx_done(tx_done),
    .carrier_in(carrier_in), .tx_full(n_txf), .rx_full(n_rxf),
    .rx_empty(n_rxe), .busy(n_busy), .dcd(n_dcd));

  // serializer stand-in
  always @(posedge clk) begin
    if (rst) sh_cnt <= 0;
    else if (tx_valid && tx_ready) sh_cnt <= sh_len;
    else if (sh_cnt > 0) sh_cnt <= sh_cnt - 1;
  end

  // reference model
  logic [DW-1:0] txq[$], rxq[$];
  bit m_mode, m_act, m_txf, m_rxf, m_rxe, m_busy, m_dcd;

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_mode = fifo_en; m_act = 0;
      m_txf = 0; m_rxf = 0; m_rxe = 1; m_busy = 0; m_dcd = 0;
    end else begin
      int cap;
      bit pop;
      cap = fifo_en ? DEPTH : 1;
      pop = 0;
      if (fifo_en != m_mode) begin
        txq.delete(); rxq.delete();
      end else begin
        int tsz, rsz;
        tsz = txq.size(); rsz = rxq.size();
        pop = uart_en && (tsz > 0) && tx_ready;
        if (pop) void'(txq.pop_front());
        if (cpu_wr_en && tsz < cap) txq.push_back(cpu_wr_data);
        if (cpu_rd_en && rsz > 0) void'(rxq.pop_front());
        if (rx_valid && rsz < cap) rxq.push_back(rx_data);
      end
      if (pop) m_act = 1;
      else if (tx_done) m_act = 0;
      m_txf = txq.size() >= cap;
      m_rxf = rxq.size() >= cap;
      m_rxe = rxq.size() == 0;
      m_busy = (txq.size() > 0) || m_act;
      m_dcd = carrier_in;
      m_mode = fifo_en;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs settle and before the next edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      bit exp_v;
      exp_v = uart_en && (txq.size() > 0) && (fifo_en == m_mode);
      chk("R3 tx_full", DW'(tx_full), DW'(m_txf));
      chk("R4 rx_full", DW'(rx_full), DW'(m_rxf));
      chk("R5 rx_empty", DW'(rx_empty), DW'(m_rxe));
      chk("R9/R10 busy", DW'(busy), DW'(m_busy));
      chk("R11 dcd", DW'(dcd), DW'(m_dcd));
      chk("R11 dcd without modem", DW'(n_dcd), '0);
      chk("R7/R8 tx_valid", DW'(tx_valid), DW'(exp_v));
      if (exp_v) chk("R2/R8 tx_data order", tx_data, txq[0]);
      if (rxq.size() > 0) chk("R2/R8 cpu_rd_data order", cpu_rd_data, rxq[0]);
    end
  end

  task automatic idle_in();
    cpu_wr_en = 0; cpu_rd_en = 0; rx_valid = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R6: overfill both directions with shifter stalled
  task automatic overfill(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_wr_en = 1; cpu_wr_data = DW'($urandom);
      rx_valid = 1; rx_data = DW'($urandom);
    end
    @(negedge clk); idle_in();
  endtask

  task automatic drain_rx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cpu_rd_en = 1;
    end
    @(negedge clk); idle_in();
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 0;
    #1;
    // R1: reset state
    chk("R1 rx_empty after reset", DW'(rx_empty), 8'd1);
    chk("R1 flags low after reset", DW'({rx_full, tx_full, busy, dcd}), 8'd0);

    // hold mode, UART disabled: busy rises with queued data (R9), one-byte capacity (R2, R6)
    uart_en = 0; fifo_en = 0;
    overfill(3);
    cyc(3);
    drain_rx(2);
    // enable UART: byte goes out, busy held until done (R10)
    sh_len = 6; ready_en = 1; uart_en = 1;
    cyc(12);

    // switch to queue mode (R7), overfill past DEPTH
    ready_en = 0;
    @(negedge clk); fifo_en = 1;
    cyc(2);
    uart_en = 0;
    overfill(DEPTH + 4);
    cyc(2);
    drain_rx(DEPTH + 2);
    // refill rx, then flip mode with data present (R7)
    overfill(5);
    @(negedge clk); fifo_en = 0;
    cyc(3);
    @(negedge clk); fifo_en = 1;
    overfill(DEPTH);
    // drain tx with varied shifter length and intermittent ready (R8, R10)
    uart_en = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ready_en = ($urandom % 3) != 0;
      sh_len = 1 + ($urandom % 7);
      carrier_in = $urandom;
    end

    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cpu_wr_en = ($urandom % 3) == 0;
      cpu_wr_data = DW'($urandom);
      rx_valid = ($urandom % 3) == 0;
      rx_data = DW'($urandom);
      cpu_rd_en = ($urandom % 4) == 0;
      ready_en = ($urandom % 4) != 0;
      sh_len = 1 + ($urandom % 5);
      uart_en = ($urandom % 40) != 0;
      carrier_in = ($urandom % 5) == 0 ? ~carrier_in : carrier_in;
      if (($urandom % 250) == 0) fifo_en = ~fifo_en;
    end
    @(negedge clk); idle_in();
    cyc(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule